// File: doc/BRIEF.md
# Multi-lane SPI master serial engine

This block is the shifting core of an SPI controller. Its word source is a first-word-fall-through transmit queue outside the block, and its word sink is a receive queue. Each queued word starts one 32-bit frame on the serial clock. The frame uses one, two or four data lanes and any of the four clock polarity/phase combinations. Bits go out most significant first or least significant first. The serial clock runs at a rate divided down from the system clock. In receive mode each frame captures lane input into a word and pushes that word to the receive queue. The engine waits while that queue is full.

Chip select is active low. It comes in two forms. In automatic form the engine drives it, with a programmable lead time before the first clock edge and the same lag time after the last edge. Consecutive queued words share one select window. In manual form select simply follows a level input. A busy flag covers the whole select window, and a single-cycle completion pulse marks the return to idle. Each lane has its own output, output-enable and input, so pad logic stays outside the block. All configuration inputs must be held stable while busy is high.

Top module: `spi_lane_engine`

## Requirements
- R1: Lane mode 0 drives lane 0 and receives on lane 1. Mode 1 uses lanes 1..0 and mode 2 uses lanes 3..0, for both output and input. Mode 3 behaves as mode 0. While a transfer runs, the output enables cover the active lanes, except in receive mode with two or four lanes, where all enables are low. At idle all enables are low.
- R2: With the order flag at 1, the first lane group holds the word's top bits, with lane L-1 carrying the more significant bit. With the flag at 0, the first group holds bits L-1..0, with lane i carrying bit i. Later groups follow in the same direction.
- R3: When idle, the serial clock rests at the polarity bit. With phase 0, data is valid at every leading edge. With phase 1, data is valid at every trailing edge, and the next group appears on the following leading edge.
- R4: Within a word, successive serial clock edges are (div+1)*2 system clocks apart.
- R5: Each word produces 64, 32 or 16 serial clock edges (32, 16 or 8 clock periods) for one, two or four lanes.
- R6: In automatic select mode with delay d and half period H, select falls (2d+1)*H+1 system clocks before the first edge. It rises 2*d*H+2 system clocks after the last edge. Busy is high exactly while select is low.
- R7: In manual select mode the select output equals the level input one clock later, including during a transfer, and the engine never toggles it.
- R8: In receive mode each frame pushes the captured word to the receive queue, assembled in the same order and lane mapping as R2. If the queue is full, the engine holds with no new edges and no push until space appears. Transmit mode never pushes.
- R9: One select window carries all words queued back to back. At its end the completion pulse is high for exactly one clock. After reset the engine is idle, with busy and the pulse low and select high.
- R10: Each word pops exactly one transmit entry. With enable low the engine stays idle and pops nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows new select windows to start |
| lane_mode | input | 2 | 0 single, 1 dual, 2 quad, 3 single |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | 0 sample on leading edge, 1 on trailing edge |
| rd_mode | input | 1 | 0 transmit, 1 receive into queue |
| msb_first | input | 1 | 1 most significant bit first |
| ss_sw | input | 1 | 1 selects manual chip select |
| ss_level | input | 1 | Manual chip select level |
| ss_delay | input | 4 | Lead/lag time in serial clock periods |
| clk_div | input | 3 | Serial clock divider |
| tx_empty | input | 1 | Transmit queue empty |
| tx_data | input | 32 | Head word of transmit queue |
| tx_pop | output | 1 | Takes the head word |
| rx_full | input | 1 | Receive queue full |
| rx_push | output | 1 | Writes rx_data into receive queue |
| rx_data | output | 32 | Captured word |
| sclk | output | 1 | Serial clock |
| ss_n | output | 1 | Chip select, active low |
| dq_out | output | 4 | Lane output data |
| dq_oe | output | 4 | Lane output enables |
| dq_in | input | 4 | Lane input data |
| busy | output | 1 | Select window in progress |
| done | output | 1 | One-clock completion pulse |

## Verification
The bench builds the engine with its default parameters: 32-bit words, a 4-bit delay field and a 3-bit divider. At these values every lane encoding, clock mode, bit order and direction combination can be swept in full. Every divider setting is also within reach, as is the largest select delay, in a few thousand cycles each. A lane-level model predicts each bit group from the word index and the requested order. From the divider and delay values the model also gives the exact edge spacing and the select lead and lag times. Dedicated runs hold the receive queue full mid-window, start with enable low, and switch select to manual control.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_XFER,
    ST_WEND,
    ST_HOLD
  } eng_state_t;

  // lane count for a lane mode code; code 3 falls back to one lane
  function automatic logic [2:0] lane_count(input logic [1:0] mode);
    case (mode)
      2'd1:    lane_count = 3'd2;
      2'd2:    lane_count = 3'd4;
      default: lane_count = 3'd1;
    endcase
  endfunction

  // log2 of the lane count
  function automatic logic [1:0] lane_shift(input logic [1:0] mode);
    case (mode)
      2'd1:    lane_shift = 2'd1;
      2'd2:    lane_shift = 2'd2;
      default: lane_shift = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int CW = DIV_W + 1;

  logic [CW-1:0] cnt;

  // half period is (div+1)*2, so the terminal count is 2*div+1
  assign tick = run && (cnt == {div, 1'b1});

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  // R4: half period is at least two clocks, so ticks never touch
  a_r4_tick_spaced: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int W     = 32,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [W-1:0]     ld_word,
  input  logic             shift,
  input  logic             sample,
  input  logic [2:0]       nl,
  input  logic [LANES-1:0] lane_mask,
  input  logic             msb,
  input  logic [LANES-1:0] dq_in,
  output logic [LANES-1:0] dq_out,
  output logic [W-1:0]     rx_word
);
  logic [W-1:0]     sr;
  logic [W-1:0]     rx_q;
  logic [LANES-1:0] top_grp;
  logic [LANES-1:0] pick;
  logic [LANES-1:0] chunk;
  logic             single;

  assign single  = (nl == 3'd1);
  assign top_grp = sr[W-1 -: LANES] >> (LANES - int'(nl));
  assign pick    = msb ? top_grp : sr[LANES-1:0];
  assign chunk   = single ? LANES'(dq_in[1]) : (dq_in & lane_mask);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [2:0] LG = 3'(g);
    assign dq_out[g] = (nl > LG) ? pick[g] : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      rx_q <= '0;
    end else begin
      if (load)       sr <= ld_word;
      else if (shift) sr <= msb ? (sr << nl) : (sr >> nl);
      if (sample) begin
        if (msb) rx_q <= (rx_q << nl) | W'(chunk);
        else     rx_q <= (rx_q >> nl) | (W'(chunk) << (W - int'(nl)));
      end
    end
  end

  assign rx_word = rx_q;

  // R2: a word is never loaded on the same cycle as a serial edge
  a_r2_load_apart: assert property (@(posedge clk) disable iff (rst)
    load |-> (!shift && !sample));

endmodule

// File: rtl/spi_lane_engine.sv
module spi_lane_engine #(
  parameter int DATA_W = 32,
  parameter int DLY_W  = 4,
  parameter int DIV_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [1:0]        lane_mode,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              rd_mode,
  input  logic              msb_first,
  input  logic              ss_sw,
  input  logic              ss_level,
  input  logic [DLY_W-1:0]  ss_delay,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              tx_empty,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_pop,
  input  logic              rx_full,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_data,
  output logic              sclk,
  output logic              ss_n,
  output logic [3:0]        dq_out,
  output logic [3:0]        dq_oe,
  input  logic [3:0]        dq_in,
  output logic              busy,
  output logic              done
);
  import spi_eng_pkg::*;

  localparam int LANES = 4;
  localparam int AW    = $clog2(2 * DATA_W);
  localparam int EW    = (AW > DLY_W + 1) ? AW : DLY_W + 1;

  eng_state_t       st;
  logic [EW-1:0]    e_cnt;
  logic [EW-1:0]    last_e;
  logic [2:0]       nl;
  logic [LANES-1:0] lane_mask;
  logic             sclk_q, ss_q, busy_q, done_q, busy_nxt;
  logic             tick, run, delay_met, tx_avail, stall;
  logic             xfer_tick, smp, shf;

  assign nl        = lane_count(lane_mode);
  assign lane_mask = LANES'((1 << nl) - 1);
  assign last_e    = EW'(((2 * DATA_W) >> lane_shift(lane_mode)) - 1);
  assign delay_met = (e_cnt == EW'({ss_delay, 1'b0}));
  assign tx_avail  = enable && !tx_empty;
  assign stall     = rd_mode && rx_full;

  assign run = (st == ST_XFER) ||
               (((st == ST_SETUP) || (st == ST_HOLD)) && !delay_met);

  assign xfer_tick = (st == ST_XFER) && tick;
  assign smp = xfer_tick && (e_cnt[0] == cpha);
  assign shf = xfer_tick && (e_cnt[0] != cpha) &&
               (e_cnt != '0) && (e_cnt != last_e);

  assign tx_pop  = ((st == ST_SETUP) && delay_met) ||
                   ((st == ST_WEND) && !stall && tx_avail);
  assign rx_push = (st == ST_WEND) && rd_mode && !rx_full;

  spi_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .div  (clk_div),
    .tick (tick)
  );

  spi_shifter #(.W(DATA_W), .LANES(LANES)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (tx_pop),
    .ld_word   (tx_data),
    .shift     (shf),
    .sample    (smp),
    .nl        (nl),
    .lane_mask (lane_mask),
    .msb       (msb_first),
    .dq_in     (dq_in),
    .dq_out    (dq_out),
    .rx_word   (rx_data)
  );

  always_comb begin
    busy_nxt = busy_q;
    if ((st == ST_IDLE) && tx_avail)      busy_nxt = 1'b1;
    else if ((st == ST_HOLD) && delay_met) busy_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      e_cnt  <= '0;
      sclk_q <= cpol;
      ss_q   <= 1'b1;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      busy_q <= busy_nxt;
      ss_q   <= ss_sw ? ss_level : !busy_nxt;
      case (st)
        ST_IDLE: begin
          sclk_q <= cpol;
          if (tx_avail) begin
            st    <= ST_SETUP;
            e_cnt <= '0;
          end
        end
        ST_SETUP: begin
          if (delay_met) begin
            st    <= ST_XFER;
            e_cnt <= '0;
          end else if (tick) e_cnt <= e_cnt + 1'b1;
        end
        ST_XFER: begin
          if (tick) begin
            sclk_q <= ~sclk_q;
            if (e_cnt == last_e) begin
              st    <= ST_WEND;
              e_cnt <= '0;
            end else e_cnt <= e_cnt + 1'b1;
          end
        end
        ST_WEND: begin
          if (!stall) begin
            st    <= tx_avail ? ST_XFER : ST_HOLD;
            e_cnt <= '0;
          end
        end
        ST_HOLD: begin
          if (delay_met) begin
            st     <= ST_IDLE;
            done_q <= 1'b1;
          end else if (tick) e_cnt <= e_cnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign sclk  = sclk_q;
  assign ss_n  = ss_q;
  assign busy  = busy_q;
  assign done  = done_q;
  assign dq_oe = ((st != ST_IDLE) && !(rd_mode && (nl != 3'd1))) ? lane_mask : '0;

  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6: in automatic mode select is low exactly while busy
  a_r6_ss_follows_busy: assert property (@(posedge clk) disable iff (rst)
    !$past(ss_sw) |-> (ss_n == !busy));

  // R3: the serial clock rests at the polarity level while idle
  a_r3_idle_level: assert property (@(posedge clk) disable iff (rst)
    (!busy && $stable(cpol)) |-> (sclk == cpol));

endmodule

// File: tb/test_spi_lane_engine.sv
`timescale 1ns/1ps
module test_spi_lane_engine;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst = 1'b1, enable = 1'b0;
  logic [1:0]  lane_mode = 2'd0;
  logic        cpol = 1'b0, cpha = 1'b0, rd_mode = 1'b0, msb_first = 1'b1;
  logic        ss_sw = 1'b0, ss_level = 1'b1;
  logic [3:0]  ss_delay = 4'd0;
  logic [2:0]  clk_div = 3'd0;
  logic        tx_empty, tx_pop, rx_full = 1'b0, rx_push;
  logic [31:0] tx_data, rx_data;
  logic        sclk, ss_n, busy, done;
  logic [3:0]  dq_out, dq_oe, dq_in = 4'd0;

  spi_lane_engine i_spi_lane_engine (
    .clk(clk), .rst(rst), .enable(enable), .lane_mode(lane_mode),
    .cpol(cpol), .cpha(cpha), .rd_mode(rd_mode), .msb_first(msb_first),
    .ss_sw(ss_sw), .ss_level(ss_level), .ss_delay(ss_delay), .clk_div(clk_div),
    .tx_empty(tx_empty), .tx_data(tx_data), .tx_pop(tx_pop),
    .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_data),
    .sclk(sclk), .ss_n(ss_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in),
    .busy(busy), .done(done)
  );

  int checks = 0, errors = 0;

  // queue models
  logic [31:0] txq [0:63];
  logic [31:0] rxq [0:255];
  int tx_wr = 0, tx_rd = 0, rx_cnt = 0;
  assign tx_empty = (tx_rd == tx_wr);
  assign tx_data  = txq[tx_rd % 64];
  always @(posedge clk) begin
    if (tx_pop) tx_rd <= tx_rd + 1;
    if (rx_push) begin
      rxq[rx_cnt % 256] <= rx_data;
      rx_cnt <= rx_cnt + 1;
    end
  end

  // run configuration seen by the monitor
  int L = 1, N = 32, H = 2, seed = 0, run_id = 0;
  bit g_msb = 1, g_rd = 0, g_cpol = 0, g_cpha = 0;

  function automatic logic [31:0] txw(input int w);
    return (32'hC001_D00D + 32'(w) * 32'h0F1E_2D3C) ^ (32'(seed) * 32'h0101_0101);
  endfunction
  function automatic logic [31:0] pat(input int w);
    return (32'h9E37_79B9 * 32'(w + 3)) ^ (32'(seed) * 32'h0011_2233);
  endfunction
  function automatic logic [3:0] exp_chunk(input logic [31:0] w, input int k);
    logic [3:0] c = 4'd0;
    for (int i = 0; i < L; i++)
      c[i] = g_msb ? w[31 - k*L - (L-1-i)] : w[k*L + i];
    return c;
  endfunction
  function automatic logic [3:0] in_drive(input int idx);
    logic [3:0] c = exp_chunk(pat(idx / N), idx % N);
    return (L == 1) ? {2'b00, c[0], 1'b0} : c;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: samples away from the active edge
  int cyc = 0, seen_id = 0;
  int r_edges, r_samps, r_derr, r_gerr, r_done, r_falls, r_rises;
  int t_fall, t_first, t_last, t_rise;
  logic prev_ss = 1'b1, prev_sclk = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (run_id != seen_id) begin
      seen_id = run_id;
      r_edges = 0; r_samps = 0; r_derr = 0; r_gerr = 0; r_done = 0;
      r_falls = 0; r_rises = 0; t_fall = 0; t_first = 0; t_last = 0; t_rise = 0;
      dq_in = in_drive(0);
    end else begin
      if (prev_ss && !ss_n) begin r_falls++; t_fall = cyc; end
      if (!prev_ss && ss_n) begin r_rises++; t_rise = cyc; end
      if (sclk !== prev_sclk) begin
        bit lead;
        if (r_edges == 0) t_first = cyc;
        else if ((r_edges % (2*N)) != 0 && (cyc - t_last) != H) r_gerr++;
        t_last = cyc;
        r_edges++;
        lead = (sclk != g_cpol);
        if (lead == (g_cpha == 1'b0)) begin
          logic [3:0] mask, eoe;
          mask = 4'((1 << L) - 1);
          eoe  = (g_rd && L > 1) ? 4'd0 : mask;
          if (dq_oe !== eoe) r_derr++;
          if (eoe != 4'd0 && (dq_out & mask) !== exp_chunk(txw(r_samps / N), r_samps % N))
            r_derr++;
          r_samps++;
          dq_in = in_drive(r_samps);
        end
      end
      if (done) r_done++;
    end
    prev_ss = ss_n;
    prev_sclk = sclk;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 190000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run(input int m, input int cp, input bit mb, input bit rd,
                     input int dv, input int d, input int nw,
                     input bit stall, input bit late, input bit sw);
    int tx_base, rx_base;
    lane_mode = 2'(m); cpol = cp[1]; cpha = cp[0]; msb_first = mb; rd_mode = rd;
    clk_div = 3'(dv); ss_delay = 4'(d);
    ss_sw = sw; ss_level = sw ? 1'b0 : 1'b1;
    L = (m == 1) ? 2 : (m == 2) ? 4 : 1;
    N = 32 / L; H = (dv + 1) * 2;
    g_msb = mb; g_rd = rd; g_cpol = cp[1]; g_cpha = cp[0];
    seed++;
    repeat (2) @(negedge clk);
    tx_base = tx_rd; rx_base = rx_cnt;
    for (int i = 0; i < nw; i++) txq[(tx_wr + i) % 64] = txw(i);
    tx_wr = tx_wr + nw;
    run_id++;
    @(negedge clk);
    rx_full = stall;
    if (late) begin
      repeat (30) @(negedge clk);
      chk(!busy && ss_n && tx_rd == tx_base && r_edges == 0, "R10 idle while disabled", busy, 0);
    end
    enable = 1'b1;
    if (stall) begin
      while (r_edges < 2*N) @(negedge clk);
      repeat (40) @(negedge clk);
      chk(rx_cnt == rx_base && r_edges == 2*N && busy && !ss_n,
          "R8 hold while queue full", rx_cnt - rx_base, 0);
      rx_full = 1'b0;
    end
    while (r_done == 0) @(negedge clk);
    enable = 1'b0;
    repeat (3) @(negedge clk);
    chk(r_derr == 0, "R1 R2 R3 lane data and enables", r_derr, 0);
    chk(r_gerr == 0, "R4 half period spacing", r_gerr, 0);
    chk(r_edges == 2*N*nw, "R5 edges per word", r_edges, 2*N*nw);
    chk(tx_rd - tx_base == nw, "R10 one pop per word", tx_rd - tx_base, nw);
    chk(r_done == 1 && !busy, "R9 single done pulse", r_done, 1);
    if (sw) begin
      chk(r_falls == 0 && r_rises == 0 && !ss_n, "R7 manual select held", r_rises, 0);
    end else begin
      chk(t_first - t_fall == (2*d+1)*H + 1, "R6 select lead", t_first - t_fall, (2*d+1)*H + 1);
      chk(t_rise - t_last == 2*d*H + 2, "R6 select lag", t_rise - t_last, 2*d*H + 2);
      chk(r_falls == 1 && r_rises == 1, "R9 one window for all words", r_falls, 1);
    end
    if (rd) begin
      chk(rx_cnt - rx_base == nw, "R8 push count", rx_cnt - rx_base, nw);
      for (int i = 0; i < nw; i++)
        chk(rxq[(rx_base + i) % 256] == pat(i), "R8 received word",
            rxq[(rx_base + i) % 256], pat(i));
    end else begin
      chk(rx_cnt == rx_base, "R8 no push when transmitting", rx_cnt - rx_base, 0);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ss_n && !busy && !done, "R9 reset state", {ss_n, busy, done}, 3'b100);
    chk(dq_oe == 4'd0 && sclk == cpol, "R1 R3 reset idle lanes", {dq_oe, sclk}, 0);

    for (int m = 0; m < 4; m++)
      for (int cp = 0; cp < 4; cp++)
        for (int mb = 0; mb < 2; mb++)
          for (int rd = 0; rd < 2; rd++)
            run(m, cp, mb[0], rd[0], 0, m, 2, 1'b0, 1'b0, 1'b0);

    for (int dv = 0; dv < 8; dv++)
      run(dv % 3, dv % 4, dv[0], dv[2], dv, (dv * 5) % 16, 1, 1'b0, 1'b0, 1'b0);

    run(2, 3, 1'b1, 1'b1, 1, 15, 2, 1'b0, 1'b0, 1'b0);
    run(2, 1, 1'b0, 1'b1, 0, 1, 3, 1'b1, 1'b0, 1'b0);
    run(0, 2, 1'b1, 1'b1, 0, 0, 2, 1'b1, 1'b0, 1'b0);
    run(1, 0, 1'b1, 1'b0, 0, 2, 2, 1'b0, 1'b1, 1'b0);
    run(0, 0, 1'b1, 1'b0, 0, 0, 2, 1'b0, 1'b0, 1'b1);

    // R7: manual level appears one clock later
    ss_level = 1'b1;
    @(negedge clk);
    chk(ss_n == 1'b1, "R7 manual high", ss_n, 1);
    ss_level = 1'b0;
    @(negedge clk);
    chk(ss_n == 1'b0, "R7 manual low", ss_n, 0);
    ss_sw = 1'b0;
    @(negedge clk);
    chk(ss_n == 1'b1 && !busy, "R6 automatic idle high", ss_n, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule